// File: doc/BRIEF.md
# Multi-Mode Configurable I/O Port

This block is an eight-pin (parameterisable) I/O port that a microcontroller maps into its address space through a four-location register window. Each pin runs in one of three roles. In register I/O it is a plain output or input under software control. In logic I/O it connects to the neighbouring programmable logic, which supplies a value and an enable term and reads the pad back. In address output it drives a byte of the microcontroller's address onto the pad.

For a microcontroller with a shared address/data bus, an address latch follows the bus while the latch-enable strobe is high and keeps the last value once the strobe drops. For a separate address bus the latch is left out and the chosen address byte goes straight through. A build option leaves out the mode-select register, so that every pin stays in register I/O unless the address-output term claims it.

Top module: `cfg_io_port`

## Requirements
- R1: While `rst_n` is low, the mode-select, direction and output-value registers clear to 0. With all logic and address terms inactive, every pad is then undriven (`pad_oe` = 0).
- R2: A write with `wr_en` high stores `wr_data` at the rising clock edge. The offset `reg_addr` = 1 selects the mode-select register, 2 the output-value register and 3 the direction register. Reads are combinational: offset 0 returns `pad_in`, and offsets 1, 2 and 3 return the stored registers.
- R3: A write to offset 0 changes no register.
- R4: A pin is in register I/O when its address condition is false, its `pld_sel` bit is 0 and its mode bit is 0. In that state it drives its output-value bit, and `pad_oe` is set by its direction bit OR'd with its `pld_oe` bit.
- R5: In register I/O with the pad undriven, a read at offset 0 returns the external pad level.
- R6: A pin whose `pld_sel` bit is 1 and whose address condition is false is in logic I/O. It drives `pld_out`, and `pad_oe` is high only when both the `pld_oe` bit and the direction bit are 1.
- R7: `pld_in` always equals `pad_in`, whatever the pin's role.
- R8: A pin is in address output when its `addr_oe` bit is 1, or when both its mode bit and its direction bit are 1. In that role it drives the corresponding address bit with `pad_oe` high.
- R9: When several roles qualify for a pin, address output wins over logic I/O, and logic I/O wins over register I/O.
- R10: With `MUX_BUS` = 1, the address byte is taken from `bus_ad` bits [`ADDR_LSB` +: `WIDTH`]. It follows the bus while `ale` is high and holds its value after `ale` falls. The strobe must be high at one rising clock edge or more.
- R11: With `MUX_BUS` = 0, the address byte is `bus_ad`[`ADDR_LSB` +: `WIDTH`] directly, and `ale` has no effect.
- R12: With `HAS_CTRL` = 0, offset 1 reads 0 and writes to it have no effect, so only `addr_oe` can put a pin in address output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset in the port window |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Combinational read data |
| bus_ad | input | ADDR_W | Shared address/data bus, or the address bus |
| ale | input | 1 | Address latch enable |
| addr_oe | input | WIDTH | Per-pin address-output term |
| pld_sel | input | WIDTH | Per-pin assignment to logic I/O |
| pld_out | input | WIDTH | Output value from the programmable logic |
| pld_oe | input | WIDTH | Output-enable term from the programmable logic |
| pld_in | output | WIDTH | Pad value tapped for the programmable logic |
| pad_out | output | WIDTH | Value presented to the pad drivers |
| pad_oe | output | WIDTH | Pad driver enable, 1 = drive |
| pad_in | input | WIDTH | Value sensed at the pads |

## Verification
The assertions assume that `ale` is high at one rising clock edge or more whenever a new address must be held. They also assume that the control inputs are free of X after reset. The latch-hold property relies on this: a strobe narrower than a clock period would leave the held value stale. The bench changes `ale` and all other inputs only on falling clock edges and keeps every strobe high across one full rising edge. It drives every term input with a defined value from time zero.

// File: rtl/io_port_pkg.sv
// Package: shared register offsets and pin-role encoding for the I/O port.
// Assumes a four-location register window addressed by a 2-bit offset.
package io_port_pkg;
    localparam int OFFS_W = 2;
    localparam logic [OFFS_W-1:0] OFFS_PADS = 2'd0;
    localparam logic [OFFS_W-1:0] OFFS_MODE = 2'd1;
    localparam logic [OFFS_W-1:0] OFFS_OVAL = 2'd2;
    localparam logic [OFFS_W-1:0] OFFS_DIR  = 2'd3;

    typedef enum logic [1:0] {
        ROLE_REG  = 2'd0,
        ROLE_LOGC = 2'd1,
        ROLE_ADDR = 2'd2
    } pin_role_e;
endpackage

// File: rtl/port_regs.sv
// Register file of the port: mode-select, output value and direction, plus
// the combinational read mux. Assumes writes take effect at the clock edge.
// With HAS_CTRL = 0 the mode-select register is absent and reads as 0.
module port_regs
    import io_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  mode_q,
    output logic [WIDTH-1:0]  oval_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  rd_data
);
    // Output-value and direction registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oval_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (reg_addr == OFFS_OVAL) oval_q <= wr_data;
            if (reg_addr == OFFS_DIR)  dir_q  <= wr_data;
        end
    end

    generate
        if (HAS_CTRL) begin : g_mode
            // Mode-select register, present only in the full build.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mode_q <= '0;
                else if (wr_en && reg_addr == OFFS_MODE)
                    mode_q <= wr_data;
            end
        end else begin : g_nomode
            assign mode_q = '0;
        end
    endgenerate

    // Read mux over the four window locations.
    always_comb begin
        unique case (reg_addr)
            OFFS_PADS: rd_data = pad_in;
            OFFS_MODE: rd_data = mode_q;
            OFFS_OVAL: rd_data = oval_q;
            default:   rd_data = dir_q;
        endcase
    end
endmodule

// File: rtl/port_addr_latch.sv
// Address capture for the port. With MUX_BUS = 1 it follows the bus while
// the strobe is high and keeps the last value once the strobe is low; the
// strobe must cover one rising clock edge or more. With MUX_BUS = 0 it passes the bus slice through.
module port_addr_latch #(
    parameter int WIDTH    = 8,
    parameter int ADDR_W   = 16,
    parameter int ADDR_LSB = 0,
    parameter bit MUX_BUS  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_ad,
    input  logic              ale,
    output logic [WIDTH-1:0]  addr_bits
);
    logic [WIDTH-1:0] bus_slice;
    assign bus_slice = bus_ad[ADDR_LSB +: WIDTH];

    generate
        if (MUX_BUS) begin : g_latch
            logic [WIDTH-1:0] held_q;
            // Capture the bus slice on every edge while the strobe is high.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    held_q <= '0;
                else if (ale)
                    held_q <= bus_slice;
            end
            assign addr_bits = ale ? bus_slice : held_q;
        end else begin : g_bypass
            assign addr_bits = bus_slice;
        end
    endgenerate
endmodule

// File: rtl/port_pin_mux.sv
// Per-pin role selection and pad drive. Address output wins over logic I/O,
// which wins over register I/O. Purely combinational.
module port_pin_mux
    import io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] mode_q,
    input  logic [WIDTH-1:0] oval_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] addr_bits,
    input  logic [WIDTH-1:0] addr_oe,
    input  logic [WIDTH-1:0] pld_sel,
    input  logic [WIDTH-1:0] pld_out,
    input  logic [WIDTH-1:0] pld_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_role_e role;

        // Pick the pin's role by priority.
        always_comb begin
            if (addr_oe[i] || (mode_q[i] && dir_q[i]))
                role = ROLE_ADDR;
            else if (pld_sel[i])
                role = ROLE_LOGC;
            else
                role = ROLE_REG;
        end

        // Drive value and enable for the chosen role.
        always_comb begin
            unique case (role)
                ROLE_ADDR: begin
                    pad_out[i] = addr_bits[i];
                    pad_oe[i]  = 1'b1;
                end
                ROLE_LOGC: begin
                    pad_out[i] = pld_out[i];
                    pad_oe[i]  = pld_oe[i] & dir_q[i];
                end
                default: begin
                    pad_out[i] = oval_q[i];
                    pad_oe[i]  = dir_q[i] | pld_oe[i];
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_io_port.sv
// Top of the multi-mode I/O port: register window, address capture and
// per-pin role mux. Assumes a single clock and synchronous active-low reset.
module cfg_io_port
    import io_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ADDR_W   = 16,
    parameter int ADDR_LSB = 0,
    parameter bit MUX_BUS  = 1'b1,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [ADDR_W-1:0] bus_ad,
    input  logic              ale,
    input  logic [WIDTH-1:0]  addr_oe,
    input  logic [WIDTH-1:0]  pld_sel,
    input  logic [WIDTH-1:0]  pld_out,
    input  logic [WIDTH-1:0]  pld_oe,
    output logic [WIDTH-1:0]  pld_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic [WIDTH-1:0]  pad_in
);
    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] oval_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] addr_bits;

    port_regs #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .pad_in(pad_in), .mode_q(mode_q),
        .oval_q(oval_q), .dir_q(dir_q), .rd_data(rd_data)
    );

    port_addr_latch #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB),
                      .MUX_BUS(MUX_BUS)) i_alat (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ale(ale),
        .addr_bits(addr_bits)
    );

    port_pin_mux #(.WIDTH(WIDTH)) i_mux (
        .mode_q(mode_q), .oval_q(oval_q), .dir_q(dir_q),
        .addr_bits(addr_bits), .addr_oe(addr_oe), .pld_sel(pld_sel),
        .pld_out(pld_out), .pld_oe(pld_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Input tap towards the programmable logic.
    assign pld_in = pad_in;
endmodule

// File: rtl/cfg_io_port_chk.sv
// Checker for cfg_io_port, bound to every instance. Assumes the strobe spans
// one rising clock edge or more and that inputs carry no X after reset.
module cfg_io_port_chk #(
    parameter int WIDTH   = 8,
    parameter bit MUX_BUS = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       reg_addr,
    input logic             ale,
    input logic [WIDTH-1:0] addr_oe,
    input logic [WIDTH-1:0] pld_sel,
    input logic [WIDTH-1:0] pld_oe,
    input logic [WIDTH-1:0] pld_in,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] mode_q,
    input logic [WIDTH-1:0] oval_q,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] addr_bits
);
    logic [WIDTH-1:0] addr_pins;
    logic [WIDTH-1:0] idle_pins;
    assign addr_pins = addr_oe | (mode_q & dir_q);
    assign idle_pins = ~(addr_pins | pld_sel | mode_q | dir_q | pld_oe);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && oval_q == '0 && dir_q == '0));

    assert_offset0_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd0) |=>
            ($stable(mode_q) && $stable(oval_q) && $stable(dir_q)));

    assert_idle_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & idle_pins) == '0);

    assert_tap_follows_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pld_in == pad_in);

    assert_addr_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & addr_pins) == addr_pins) &&
        ((pad_out & addr_pins) == (addr_bits & addr_pins)));

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (MUX_BUS && !ale && $past(!ale)) |-> $stable(addr_bits));
endmodule

bind cfg_io_port cfg_io_port_chk #(.WIDTH(WIDTH), .MUX_BUS(MUX_BUS)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .ale(ale),
    .addr_oe(addr_oe), .pld_sel(pld_sel), .pld_oe(pld_oe), .pld_in(pld_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .mode_q(mode_q),
    .oval_q(oval_q), .dir_q(dir_q), .addr_bits(addr_bits)
);

// File: tb/test_cfg_io_port.sv
// Bench for cfg_io_port: a vector table walked by one loop, then directed
// tests for reset, register window, latch, bypass and no-mode-register build.
module test_cfg_io_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] bus_ad = '0;
    logic        ale = 1'b0;
    logic [7:0]  addr_oe = '0, pld_sel = '0, pld_out = '0, pld_oe = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  rd_data, pld_in, pad_out, pad_oe;
    logic [7:0]  b_rd_data, b_pld_in, b_pad_out, b_pad_oe;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    cfg_io_port i_cfg_io_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .bus_ad(bus_ad), .ale(ale),
        .addr_oe(addr_oe), .pld_sel(pld_sel), .pld_out(pld_out),
        .pld_oe(pld_oe), .pld_in(pld_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_in(pad_in)
    );

    // Variant: no mode register, separate address bus, high address byte.
    cfg_io_port #(.MUX_BUS(1'b0), .HAS_CTRL(1'b0), .ADDR_LSB(8)) i_cfg_io_port_alt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(b_rd_data), .bus_ad(bus_ad), .ale(ale),
        .addr_oe(addr_oe), .pld_sel(pld_sel), .pld_out(pld_out),
        .pld_oe(pld_oe), .pld_in(b_pld_in), .pad_out(b_pad_out),
        .pad_oe(b_pad_oe), .pad_in(pad_in)
    );

    // Fields: mode, dir, oval, pld_sel, pld_out, pld_oe, addr_oe, addr, exp_oe, exp_out(masked)
    localparam logic [79:0] VEC [8] = '{
        80'h00_F0_A5_00_00_00_00_00_F0_A0,  // R4 register output
        80'h00_00_3C_00_00_0F_00_00_0F_0C,  // R4 enable from term
        80'h00_FF_00_FF_96_F0_00_00_F0_90,  // R6 logic I/O
        80'h00_0F_00_FF_FF_FF_00_00_0F_0F,  // R6 direction gate
        80'hFF_FF_00_00_00_00_00_5A_FF_5A,  // R8 via mode and direction
        80'h00_00_00_00_00_00_33_C3_33_03,  // R8 via address term
        80'hF0_FF_00_FF_0F_FF_00_AA_FF_AF,  // R9 address over logic
        80'h0F_0F_00_FF_00_00_00_81_0F_01   // R9 address over logic I/O selection
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_addr(input logic [15:0] v);
        @(negedge clk);
        bus_ad = v; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; bus_ad = 16'hFFFF;
    endtask

    initial begin
        #1_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        reg_addr = 2'd1; #1;
        check(rd_data == 8'h00, "R1 mode", {8'h0, rd_data}, 16'h0);
        check(pad_oe == 8'h00, "R1 pads", {8'h0, pad_oe}, 16'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 8; k++) begin
            logic [79:0] v;
            v = VEC[k];
            wr(2'd1, v[79:72]);
            wr(2'd3, v[71:64]);
            wr(2'd2, v[63:56]);
            load_addr({8'h00, v[23:16]});
            pld_sel = v[55:48]; pld_out = v[47:40]; pld_oe = v[39:32];
            addr_oe = v[31:24];
            #1;
            check(pad_oe == v[15:8], "R4/R6/R8/R9 vector oe", {8'(k), pad_oe}, {8'(k), v[15:8]});
            check((pad_out & pad_oe) == v[7:0], "R4/R6/R8/R9 vector out",
                  {8'(k), pad_out & pad_oe}, {8'(k), v[7:0]});
            pld_sel = '0; pld_out = '0; pld_oe = '0; addr_oe = '0;
        end

        // R2: readback at each offset
        wr(2'd1, 8'h12); wr(2'd2, 8'h34); wr(2'd3, 8'h56);
        reg_addr = 2'd1; #1; check(rd_data == 8'h12, "R2 mode", {8'h0, rd_data}, 16'h12);
        reg_addr = 2'd2; #1; check(rd_data == 8'h34, "R2 oval", {8'h0, rd_data}, 16'h34);
        reg_addr = 2'd3; #1; check(rd_data == 8'h56, "R2 dir", {8'h0, rd_data}, 16'h56);

        // R3: write to offset 0 leaves registers alone
        wr(2'd0, 8'hFF);
        reg_addr = 2'd1; #1; check(rd_data == 8'h12, "R3 mode", {8'h0, rd_data}, 16'h12);
        reg_addr = 2'd2; #1; check(rd_data == 8'h34, "R3 oval", {8'h0, rd_data}, 16'h34);
        reg_addr = 2'd3; #1; check(rd_data == 8'h56, "R3 dir", {8'h0, rd_data}, 16'h56);

        // R5 / R7: input path
        wr(2'd1, 8'h00); wr(2'd3, 8'h00);
        pad_in = 8'hC9; reg_addr = 2'd0; #1;
        check(pad_oe == 8'h00, "R5 undriven", {8'h0, pad_oe}, 16'h0);
        check(rd_data == 8'hC9, "R5 data in", {8'h0, rd_data}, 16'hC9);
        check(pld_in == 8'hC9, "R7 tap", {8'h0, pld_in}, 16'hC9);

        // R10: transparent then hold
        wr(2'd1, 8'hFF); wr(2'd3, 8'hFF);
        @(negedge clk); bus_ad = 16'h0012; ale = 1'b1; #1;
        check(pad_out == 8'h12, "R10 transparent", {8'h0, pad_out}, 16'h12);
        @(negedge clk); ale = 1'b0; bus_ad = 16'h0034; #1;
        check(pad_out == 8'h12, "R10 hold", {8'h0, pad_out}, 16'h12);
        @(negedge clk); #1;
        check(pad_out == 8'h12, "R10 hold later", {8'h0, pad_out}, 16'h12);

        // R12: no mode register; mode+dir writes do not select address role
        reg_addr = 2'd1; #1;
        check(b_rd_data == 8'h00, "R12 mode reads 0", {8'h0, b_rd_data}, 16'h0);
        wr(2'd2, 8'h00);
        #1;
        check(b_pad_oe == 8'hFF && b_pad_out == 8'h00, "R12 stays register I/O",
              {b_pad_oe, b_pad_out}, 16'hFF00);

        // R11: bypass, high byte, strobe ignored
        @(negedge clk); addr_oe = 8'hFF; bus_ad = 16'h7E34; ale = 1'b0; #1;
        check(b_pad_out == 8'h7E, "R11 bypass", {8'h0, b_pad_out}, 16'h7E);
        bus_ad = 16'h6534; #1;
        check(b_pad_out == 8'h65, "R11 follows bus", {8'h0, b_pad_out}, 16'h65);
        addr_oe = '0;

        // R1: reset again clears registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); reg_addr = 2'd3; #1;
        check(rd_data == 8'h00, "R1 dir after reset", {8'h0, rd_data}, 16'h0);
        check(pad_oe == 8'h00, "R1 pads after reset", {8'h0, pad_oe}, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule